// File: doc/BRIEF.md
# NAND Bad-Block Table Scanner

This block builds the bad-block table for a NAND array right after power-up. It walks every erase block in ascending order through a single-byte read port that carries block, page and column. It reads the factory marker byte in the first spare-area byte of page 0, and of page 1 when it needs to. The result for each block goes into a one-bit-per-block bitmap. Block 0 is known good and is never read.

When the scan finishes, the block raises `ready`. From then on a lookup port reports whether any block is bad, together with the number of bad blocks and a flag that says whether the device holds enough good blocks to qualify. Until `ready` rises, every lookup answers "bad" and the flag stays low. Erase and program logic that consults the table therefore fails safe. A `start` pulse clears the table and runs the scan again at any time. If a read is still outstanding, its late response is discarded.

The read port allows one outstanding read at a time. The scanner pulses `rd_req` for one cycle and holds the address until `rsp_valid` returns the byte, one or more cycles later.

Top module: `nand_bbt_scan`

## Requirements
- R1: Block 0 is never read, and once `ready` is high a lookup of block 0 returns good (`lk_bad` = 0) whatever its marker holds.
- R2: Reads go out for blocks 1 to NUM_BLOCKS-1 in ascending order. Each read uses column MARKER_COL (2048 by default), and page 0 of a block is read before page 1. `rd_page` is always 0 or 1.
- R3: Page 1 of a block is read only when its page 0 marker returned 0xFF. Otherwise the scan moves straight to the next block.
- R4: A block whose page 0 or page 1 marker differs from 0xFF reads as bad (`lk_bad` = 1) once `ready` is high. All other blocks read as good.
- R5: Once `ready` is high, `bad_count` equals the number of bad blocks in the table.
- R6: Once `ready` is high, `qualified` is 1 exactly when `bad_count` is at most NUM_BLOCKS-MIN_GOOD.
- R7: While `ready` is low, `lk_bad` is 1 and `qualified` is 0.
- R8: A `start` pulse drops `ready`, clears the table and `bad_count` on the next cycle, and reruns the full scan. A read outstanding at that moment has its response discarded.
- R9: At most one read is outstanding. The address stays stable until the response arrives. A `rsp_valid` with no read outstanding changes nothing, and with `ready` high and no `start`, `ready` and `bad_count` hold.
- R10: After reset the scan begins on its own, with no `start`, and `ready` rises after the last block has been decided.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| start | input | 1 | Pulse: clear the table and rescan |
| rd_req | output | 1 | One-cycle read request |
| rd_blk | output | BLK_W | Block address of the read |
| rd_page | output | PAGE_W | Page within the block (0 or 1) |
| rd_col | output | COL_W | Column address (marker location) |
| rsp_valid | input | 1 | Read response strobe |
| rsp_byte | input | 8 | Read response data |
| lk_blk | input | BLK_W | Lookup block number |
| lk_bad | output | 1 | 1 = block bad or table not ready |
| bad_count | output | CNT_W | Number of bad blocks |
| qualified | output | 1 | Device has at least MIN_GOOD good blocks |
| ready | output | 1 | Table complete |

## Verification
The bench builds the scanner with NUM_BLOCKS = 32 and MIN_GOOD = 28, so a full scan takes a few hundred cycles and the qualification limit sits at 4 bad blocks. That makes both the pass-at-exactly-4 and fail-at-5 boundaries, as well as the last block's page-1 marker, cheap to reach. The device model answers with latencies of 1, 2 and 3 cycles. It restarts the scan while a read is outstanding and injects a stray response after completion. Block 0 is given a bad-looking marker to show it is skipped.

// File: rtl/nbt_pkg.sv
package nbt_pkg;
  localparam logic [7:0] ERASED_BYTE = 8'hFF;

  typedef enum logic [2:0] {
    ST_BOOT,
    ST_ISSUE,
    ST_WAIT,
    ST_FLUSH,
    ST_DONE
  } scan_st_e;
endpackage

// File: rtl/nbt_rst_sync.sv
module nbt_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_sync = sync_q[STAGES-1];
endmodule

// File: rtl/nbt_seq.sv
module nbt_seq
  import nbt_pkg::*;
#(
  parameter int NUM_BLOCKS = 2048,
  localparam int BLK_W = $clog2(NUM_BLOCKS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             rsp_valid,
  input  logic [7:0]       rsp_byte,
  output logic             rd_req,
  output logic [BLK_W-1:0] rd_blk,
  output logic             rd_pg1,
  output logic             clr,
  output logic             mark_bad,
  output logic             done
);
  localparam logic [BLK_W-1:0] FIRST_BLK = BLK_W'(1);
  localparam logic [BLK_W-1:0] LAST_BLK  = BLK_W'(NUM_BLOCKS - 1);

  scan_st_e         st_q, st_d;
  logic [BLK_W-1:0] blk_q, blk_d;
  logic             pg_q, pg_d;
  logic             in_flight;

  // a read is physically outstanding in these states
  assign in_flight = (st_q == ST_ISSUE) ||
                     ((st_q == ST_WAIT || st_q == ST_FLUSH) && !rsp_valid);

  always_comb begin
    st_d     = st_q;
    blk_d    = blk_q;
    pg_d     = pg_q;
    clr      = 1'b0;
    mark_bad = 1'b0;
    if (start) begin
      clr   = 1'b1;
      blk_d = FIRST_BLK;
      pg_d  = 1'b0;
      st_d  = in_flight ? ST_FLUSH : ST_ISSUE;
    end else begin
      unique case (st_q)
        ST_BOOT: begin
          blk_d = FIRST_BLK;
          pg_d  = 1'b0;
          st_d  = ST_ISSUE;
        end
        ST_ISSUE: st_d = ST_WAIT;
        ST_WAIT: begin
          if (rsp_valid) begin
            if (rsp_byte == ERASED_BYTE && !pg_q) begin
              pg_d = 1'b1;
              st_d = ST_ISSUE;
            end else begin
              mark_bad = (rsp_byte != ERASED_BYTE);
              pg_d     = 1'b0;
              if (blk_q == LAST_BLK) begin
                st_d = ST_DONE;
              end else begin
                blk_d = blk_q + BLK_W'(1);
                st_d  = ST_ISSUE;
              end
            end
          end
        end
        ST_FLUSH: if (rsp_valid) st_d = ST_ISSUE;
        ST_DONE:  st_d = ST_DONE;
        default:  st_d = ST_BOOT;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= ST_BOOT;
      blk_q <= '0;
      pg_q  <= 1'b0;
    end else begin
      st_q  <= st_d;
      blk_q <= blk_d;
      pg_q  <= pg_d;
    end
  end

  assign rd_req = (st_q == ST_ISSUE);
  assign rd_blk = blk_q;
  assign rd_pg1 = pg_q;
  assign done   = (st_q == ST_DONE);
endmodule

// File: rtl/nbt_bitmap.sv
module nbt_bitmap #(
  parameter int NUM_BLOCKS = 2048,
  localparam int BLK_W = $clog2(NUM_BLOCKS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             we,
  input  logic [BLK_W-1:0] wr_blk,
  input  logic [BLK_W-1:0] lk_blk,
  output logic             lk_bit
);
  logic [NUM_BLOCKS-1:0] map_q, map_d;
  logic                  in_range;

  always_comb begin
    map_d = map_q;
    if (clr)     map_d = '0;
    else if (we) map_d[wr_blk] = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          map_q <= '0;
    else if (clr || we)  map_q <= map_d;
  end

  assign in_range = ({1'b0, lk_blk} < (BLK_W + 1)'(NUM_BLOCKS));
  assign lk_bit   = in_range ? map_q[lk_blk] : 1'b1;
endmodule

// File: rtl/nbt_tally.sv
module nbt_tally #(
  parameter int NUM_BLOCKS = 2048,
  parameter int MAX_BAD    = 40,
  localparam int CNT_W = $clog2(NUM_BLOCKS + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             inc,
  input  logic             ready,
  output logic [CNT_W-1:0] count,
  output logic             qualified
);
  logic [CNT_W-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (clr)      cnt_d = '0;
    else if (inc) cnt_d = cnt_q + CNT_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          cnt_q <= '0;
    else if (clr || inc) cnt_q <= cnt_d;
  end

  assign count     = cnt_q;
  assign qualified = ready && (cnt_q <= CNT_W'(MAX_BAD));
endmodule

// File: rtl/nand_bbt_scan.sv
module nand_bbt_scan #(
  parameter int NUM_BLOCKS = 2048,
  parameter int MIN_GOOD   = 2008,
  parameter int PAGE_W     = 6,
  parameter int COL_W      = 12,
  parameter int MARKER_COL = 2048,
  localparam int BLK_W = $clog2(NUM_BLOCKS),
  localparam int CNT_W = $clog2(NUM_BLOCKS + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  output logic              rd_req,
  output logic [BLK_W-1:0]  rd_blk,
  output logic [PAGE_W-1:0] rd_page,
  output logic [COL_W-1:0]  rd_col,
  input  logic              rsp_valid,
  input  logic [7:0]        rsp_byte,
  input  logic [BLK_W-1:0]  lk_blk,
  output logic              lk_bad,
  output logic [CNT_W-1:0]  bad_count,
  output logic              qualified,
  output logic              ready
);
  localparam int MAX_BAD = NUM_BLOCKS - MIN_GOOD;

  logic rst_n_s;
  logic pg1, clr, mark_bad, map_bit;

  nbt_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_s)
  );

  nbt_seq #(.NUM_BLOCKS(NUM_BLOCKS)) u_seq (
    .clk       (clk),
    .rst_n     (rst_n_s),
    .start     (start),
    .rsp_valid (rsp_valid),
    .rsp_byte  (rsp_byte),
    .rd_req    (rd_req),
    .rd_blk    (rd_blk),
    .rd_pg1    (pg1),
    .clr       (clr),
    .mark_bad  (mark_bad),
    .done      (ready)
  );

  nbt_bitmap #(.NUM_BLOCKS(NUM_BLOCKS)) u_map (
    .clk    (clk),
    .rst_n  (rst_n_s),
    .clr    (clr),
    .we     (mark_bad),
    .wr_blk (rd_blk),
    .lk_blk (lk_blk),
    .lk_bit (map_bit)
  );

  nbt_tally #(.NUM_BLOCKS(NUM_BLOCKS), .MAX_BAD(MAX_BAD)) u_tally (
    .clk       (clk),
    .rst_n     (rst_n_s),
    .clr       (clr),
    .inc       (mark_bad),
    .ready     (ready),
    .count     (bad_count),
    .qualified (qualified)
  );

  assign rd_page = {{(PAGE_W-1){1'b0}}, pg1};
  assign rd_col  = COL_W'(MARKER_COL);
  assign lk_bad  = !ready || map_bit;
endmodule

// File: rtl/nbt_chk.sv
module nbt_chk #(
  parameter int NUM_BLOCKS = 2048,
  parameter int MIN_GOOD   = 2008,
  parameter int PAGE_W     = 6,
  parameter int COL_W      = 12,
  parameter int MARKER_COL = 2048,
  localparam int BLK_W = $clog2(NUM_BLOCKS),
  localparam int CNT_W = $clog2(NUM_BLOCKS + 1)
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start,
  input logic              rd_req,
  input logic [BLK_W-1:0]  rd_blk,
  input logic [PAGE_W-1:0] rd_page,
  input logic [COL_W-1:0]  rd_col,
  input logic              rsp_valid,
  input logic [7:0]        rsp_byte,
  input logic              lk_bad,
  input logic [CNT_W-1:0]  bad_count,
  input logic              qualified,
  input logic              ready
);
  localparam int MAX_BAD = NUM_BLOCKS - MIN_GOOD;

  logic       pending;
  logic [7:0] last_byte;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pending   <= 1'b0;
      last_byte <= 8'h00;
    end else begin
      if (rd_req)         pending <= 1'b1;
      else if (rsp_valid) pending <= 1'b0;
      if (rsp_valid && pending) last_byte <= rsp_byte;
    end
  end

  AST_BLOCK0_SKIPPED: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req |-> rd_blk != '0); // R1
  AST_MARKER_COLUMN: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req |-> rd_col == COL_W'(MARKER_COL)); // R2
  AST_PAGE_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req |-> rd_page <= PAGE_W'(1)); // R2
  AST_PAGE1_AFTER_ERASED: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req && rd_page[0]) |-> last_byte == 8'hFF); // R3
  AST_QUAL_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
    ready |-> qualified == (bad_count <= CNT_W'(MAX_BAD))); // R6
  AST_FAILSAFE: assert property (@(posedge clk) disable iff (!rst_n)
    !ready |-> (lk_bad && !qualified)); // R7
  AST_START_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (!ready && bad_count == '0)); // R8
  AST_ONE_OUTSTANDING: assert property (@(posedge clk) disable iff (!rst_n)
    pending |-> !rd_req); // R9
  AST_ADDR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (pending && !$past(start)) |-> ($stable(rd_blk) && $stable(rd_page))); // R9
  AST_DONE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (ready && !start) |=> (ready && $stable(bad_count))); // R9
endmodule

bind nand_bbt_scan nbt_chk #(
  .NUM_BLOCKS (NUM_BLOCKS),
  .MIN_GOOD   (MIN_GOOD),
  .PAGE_W     (PAGE_W),
  .COL_W      (COL_W),
  .MARKER_COL (MARKER_COL)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .start     (start),
  .rd_req    (rd_req),
  .rd_blk    (rd_blk),
  .rd_page   (rd_page),
  .rd_col    (rd_col),
  .rsp_valid (rsp_valid),
  .rsp_byte  (rsp_byte),
  .lk_bad    (lk_bad),
  .bad_count (bad_count),
  .qualified (qualified),
  .ready     (ready)
);

// File: tb/tb_nand_bbt_scan.sv
module tb_nand_bbt_scan;
  localparam int NB    = 32;
  localparam int MG    = 28;
  localparam int PW    = 6;
  localparam int CW    = 12;
  localparam int MCOL  = 2048;
  localparam int BW    = $clog2(NB);
  localparam int CNTW  = $clog2(NB + 1);
  localparam int MAXB  = NB - MG;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            start = 1'b0;
  logic            rd_req;
  logic [BW-1:0]   rd_blk;
  logic [PW-1:0]   rd_page;
  logic [CW-1:0]   rd_col;
  logic            rsp_valid = 1'b0;
  logic [7:0]      rsp_byte = 8'h00;
  logic [BW-1:0]   lk_blk = '0;
  logic            lk_bad;
  logic [CNTW-1:0] bad_count;
  logic            qualified;
  logic            ready;

  nand_bbt_scan #(.NUM_BLOCKS(NB), .MIN_GOOD(MG), .PAGE_W(PW), .COL_W(CW),
                  .MARKER_COL(MCOL)) dut (.*);

  always #10 clk = ~clk;

  int n_chk = 0;
  int n_fail = 0;
  int cyc = 0;
  bit finished = 0;

  logic [7:0] mk0 [NB];
  logic [7:0] mk1 [NB];
  int exp_q[$];
  int lat = 1;
  bit spur = 0;
  bit pend = 0;
  int cnt = 0;
  int p_blk = 0;
  int p_pg = 0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d (t=%0t)", tag, act, exp, $time);
    end
  endtask

  function automatic bit exp_bad(input int b);
    return (b != 0) && (mk0[b] != 8'hFF || mk1[b] != 8'hFF);
  endfunction

  function automatic int exp_count();
    int n = 0;
    for (int b = 0; b < NB; b++) if (exp_bad(b)) n++;
    return n;
  endfunction

  task automatic build_q();
    exp_q.delete();
    for (int b = 1; b < NB; b++) begin
      exp_q.push_back(b * 2);
      if (mk0[b] == 8'hFF) exp_q.push_back(b * 2 + 1);
    end
  endtask

  task automatic all_erased();
    for (int b = 0; b < NB; b++) begin
      mk0[b] = 8'hFF;
      mk1[b] = 8'hFF;
    end
  endtask

  // device model and per-clock reference comparison
  always @(negedge clk) begin
    if (!rst_n) begin
      pend = 0;
      rsp_valid = 1'b0;
    end else begin
      if (!ready) chk(lk_bad == 1'b1 && qualified == 1'b0, "R7",
                      int'({lk_bad, qualified}), 2);
      if (rd_req) begin
        if (exp_q.size() == 0) begin
          chk(1'b0, "R2 unexpected read", int'(rd_blk), -1);
        end else begin
          int e;
          e = exp_q.pop_front();
          chk(int'(rd_blk) == e / 2, "R2 block order", int'(rd_blk), e / 2);
          chk(int'(rd_page) == e % 2, "R3 page select", int'(rd_page), e % 2);
          chk(int'(rd_col) == MCOL, "R2 column", int'(rd_col), MCOL);
        end
      end
      rsp_valid = 1'b0;
      if (pend) begin
        if (cnt <= 1) begin
          rsp_valid = 1'b1;
          rsp_byte  = (p_pg != 0) ? mk1[p_blk] : mk0[p_blk];
          pend = 0;
        end else begin
          cnt--;
        end
      end else if (spur) begin
        rsp_valid = 1'b1;
        rsp_byte  = 8'h00;
      end
      if (rd_req) begin
        pend  = 1;
        cnt   = lat;
        p_blk = int'(rd_blk);
        p_pg  = int'(rd_page);
      end
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000 && !finished) begin
      finished = 1;
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  task automatic wait_ready();
    while (!ready) @(negedge clk);
    #1;
  endtask

  task automatic pulse_start();
    @(negedge clk); #1;
    start = 1'b1;
    build_q();
    @(negedge clk); #1;
    start = 1'b0;
    chk(ready == 1'b0 && bad_count == '0, "R8 clear after start",
        int'(bad_count) + (ready ? 100 : 0), 0);
  endtask

  task automatic verify_table(input string name);
    for (int b = 0; b < NB; b++) begin
      lk_blk = BW'(b);
      #1;
      if (b == 0) chk(lk_bad == 1'b0, "R1 block 0 good", int'(lk_bad), 0);
      else        chk(lk_bad == exp_bad(b), "R4 lookup", int'(lk_bad), int'(exp_bad(b)));
    end
    chk(int'(bad_count) == exp_count(), "R5 bad count", int'(bad_count), exp_count());
    chk(qualified == (exp_count() <= MAXB), "R6 qualified", int'(qualified),
        int'(exp_count() <= MAXB));
    chk(exp_q.size() == 0, "R3 reads left over", exp_q.size(), 0);
    $display("table %s checked", name);
  endtask

  initial begin
    // pattern A: block 0 looks bad but must be skipped (R1); 9 bad on page 0 (R3)
    all_erased();
    mk0[0] = 8'h00;
    mk0[3] = 8'h00;
    mk1[7] = 8'hF0;
    mk0[9] = 8'hFE;
    mk1[9] = 8'h00;
    lat = 1;
    build_q();
    repeat (3) @(negedge clk);
    chk(ready == 1'b0 && lk_bad == 1'b1, "R7 reset state", int'(ready), 0);
    rst_n = 1'b1;
    @(negedge clk); #1;
    chk(ready == 1'b0, "R10 not ready after reset", int'(ready), 0);
    wait_ready();
    chk(ready == 1'b1, "R10 scan completes without start", int'(ready), 1);
    verify_table("A");

    // pattern C: exactly MAXB bad, last block bad on page 1 (R6 boundary)
    all_erased();
    mk0[2]  = 8'h7F;
    mk1[10] = 8'h00;
    mk0[20] = 8'h01;
    mk1[31] = 8'hFE;
    lat = 3;
    pulse_start();
    wait_ready();
    verify_table("C");

    // pattern B: one over the limit, restarted in mid-scan (R8)
    all_erased();
    mk0[1]  = 8'h00;
    mk0[5]  = 8'h12;
    mk1[6]  = 8'h00;
    mk0[17] = 8'hEF;
    mk1[31] = 8'h00;
    lat = 2;
    pulse_start();
    repeat (7) @(negedge clk);
    pulse_start();
    wait_ready();
    verify_table("B");
    chk(qualified == 1'b0, "R6 over limit", int'(qualified), 0);

    // stray response with nothing outstanding (R9)
    @(negedge clk); #1;
    spur = 1'b1;
    @(negedge clk); #1;
    spur = 1'b0;
    repeat (3) @(negedge clk);
    #1;
    chk(ready == 1'b1, "R9 ready holds", int'(ready), 1);
    chk(int'(bad_count) == exp_count(), "R9 count holds", int'(bad_count), exp_count());
    lk_blk = BW'(4);
    #1;
    chk(lk_bad == 1'b0, "R9 good block stays good", int'(lk_bad), 0);

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule